// File: doc/BRIEF.md
# Microsecond System Timer With Compare Channels

This peripheral keeps a 64-bit free-running count of microseconds and four 32-bit compare channels. A prescaler divides the system clock into a single-cycle enable at 1 MHz, and the counter advances by one on each enable. Software reads the count as two 32-bit words over a simple single-cycle register port. A read of the low word also captures the high word into a shadow, and a later read of the high word returns that shadow. The two halves then form one coherent 64-bit value even when a carry happens between the two reads.

Each compare channel holds a value that is checked against the low 32 bits of the counter. The check runs once, in the cycle after each counter step. When the counter's new low word equals a channel's value, that channel's flag in the shared status word is set and its interrupt line goes high. Both stay high until software writes a one to that flag's bit position. Accesses to read-only or unmapped locations are reported on an error output for one cycle and change nothing.

Top module: `usec_sys_timer`

## Requirements
- R1: The counter advances by exactly one every DIV system clocks, where DIV = CLK_HZ / TICK_HZ.
- R2: A read at byte offset 0x04 returns bits 31:0 of the counter. A read at 0x08 returns bits 63:32. The counter starts from zero after reset.
- R3: A read of 0x04 captures counter bits 63:32 into a shadow. A read of 0x08 returns the shadow and not the live high word.
- R4: Compare channel N (N = 0..3) is read and written at byte offset 0x0C + 4*N.
- R5: A match occurs when the counter steps to a low word equal to compare N. In the clock after the step, status bit N (bit N of the word at 0x00, bits 31:4 read as zero) and irq[N] go high. They stay high until cleared. Channels that have not matched stay low.
- R6: A write to 0x00 clears each status bit whose data bit is 1, and its irq line falls with it. Bits written as 0 keep their value. A new match in the same cycle wins over the clear.
- R7: A write to 0x04 or 0x08 leaves the counter unchanged and raises bus_err.
- R8: Offset 0x1C and any offset with address bits 1:0 not zero read as 0 and raise bus_err. Writes to them change nothing and raise bus_err.
- R9: Reset clears the counter, the status bits, all compare values and all irq lines.
- R10: bus_rdata and bus_err are valid in the clock after the access is sampled and last one cycle. A write returns 0 on bus_rdata. A valid access gives bus_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request, sampled on the rising edge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the 0x20-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Access error, one cycle after the access |
| irq | output | 4 | One interrupt line per compare channel |

## Verification
The bound checker watches four properties on every cycle. The counter steps by exactly one on each prescaler enable and holds otherwise. Two enables never come back to back. An interrupt line rises only after a fresh step whose low word equals that channel's compare value. An interrupt line falls only after an acknowledge write with its bit set. The bench scenarios show what depends on software sequences: the exact step rate over a measured window, shadow reads of the high word, compare readback, partial acknowledges that leave other flags set, error reporting on bad locations, and a reset in the middle of a run.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

    localparam int NUM_CH   = 4;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int COUNT_W  = 2 * WORD_W;
    localparam int CMP_BASE = 3;

    typedef enum logic [2:0] {
        SLOT_FLAGS  = 3'd0,
        SLOT_CNT_LO = 3'd1,
        SLOT_CNT_HI = 3'd2,
        SLOT_CMP0   = 3'd3,
        SLOT_CMP1   = 3'd4,
        SLOT_CMP2   = 3'd5,
        SLOT_CMP3   = 3'd6,
        SLOT_NONE   = 3'd7
    } slot_e;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              err;
        logic [WORD_W-1:0] shadow;
    } port_state_t;

endpackage

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = (cnt_q == CW'(DIV - 1));
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = wrap;
endmodule

// File: rtl/usec_count64.sv
module usec_count64 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] count_o,
    output logic         fresh_o
);
    typedef struct packed {
        logic [W-1:0] count;
        logic         fresh;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fresh = tick_i;
        if (tick_i) st_d.count = st_q.count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign fresh_o = st_q.fresh;
endmodule

// File: rtl/usec_match_ch.sv
module usec_match_ch #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fresh_i,
    input  logic [CMP_W-1:0] low_i,
    input  logic             load_i,
    input  logic [CMP_W-1:0] load_val_i,
    input  logic             clear_i,
    output logic [CMP_W-1:0] cmp_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             flag;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        st_d     = st_q;
        hit      = fresh_i && (low_i == st_q.cmp);
        if (load_i) st_d.cmp = load_val_i;
        st_d.flag = hit | (st_q.flag & ~clear_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o  = st_q.cmp;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/usec_sys_timer.sv
module usec_sys_timer
    import usec_timer_pkg::*;
#(
    parameter int CLK_HZ  = 250_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [NUM_CH-1:0] irq
);
    localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    logic                           tick;
    logic                           fresh;
    logic [COUNT_W-1:0]             count;
    logic [NUM_CH-1:0][WORD_W-1:0]  cmp_val;
    logic [NUM_CH-1:0]              flags;
    logic [NUM_CH-1:0]              ch_load;
    logic [NUM_CH-1:0]              ch_clear;
    slot_e                          slot;
    port_state_t                    port_d, port_q;

    usec_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    usec_count64 #(.W(COUNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .count_o (count),
        .fresh_o (fresh)
    );

    // Address decode: only word-aligned offsets map to a slot
    always_comb begin
        if (bus_addr[1:0] != 2'b00) slot = SLOT_NONE;
        else                        slot = slot_e'(bus_addr[4:2]);
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_load[i]  = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00)
                                 && (bus_addr[4:2] == 3'(CMP_BASE + i));
            assign ch_clear[i] = bus_sel && bus_wr && (slot == SLOT_FLAGS) && bus_wdata[i];

            usec_match_ch #(.CMP_W(WORD_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .fresh_i    (fresh),
                .low_i      (count[WORD_W-1:0]),
                .load_i     (ch_load[i]),
                .load_val_i (bus_wdata),
                .clear_i    (ch_clear[i]),
                .cmp_o      (cmp_val[i]),
                .flag_o     (flags[i])
            );
        end
    endgenerate

    always_comb begin
        port_d       = port_q;
        port_d.rdata = '0;
        port_d.err   = 1'b0;
        if (bus_sel) begin
            if (!bus_wr) begin
                unique case (slot)
                    SLOT_FLAGS:  port_d.rdata = WORD_W'(flags);
                    SLOT_CNT_LO: begin
                        port_d.rdata  = count[WORD_W-1:0];
                        port_d.shadow = count[COUNT_W-1:WORD_W];
                    end
                    SLOT_CNT_HI: port_d.rdata = port_q.shadow;
                    SLOT_NONE:   port_d.err   = 1'b1;
                    default: begin
                        for (int i = 0; i < NUM_CH; i++) begin
                            if (bus_addr[4:2] == 3'(CMP_BASE + i)) port_d.rdata = cmp_val[i];
                        end
                    end
                endcase
            end else begin
                if (slot == SLOT_CNT_LO || slot == SLOT_CNT_HI || slot == SLOT_NONE)
                    port_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign bus_rdata = port_q.rdata;
    assign bus_err   = port_q.err;
    assign irq       = flags;
endmodule

// File: rtl/usec_sys_timer_chk.sv
module usec_sys_timer_chk
    import usec_timer_pkg::*;
#(
    parameter int DIV = 250
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick,
    input logic                          fresh,
    input logic [COUNT_W-1:0]            count,
    input logic [NUM_CH-1:0][WORD_W-1:0] cmp_val,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [WORD_W-1:0]             bus_wdata,
    input logic                          bus_err,
    input logic [NUM_CH-1:0]             irq
);
    // R1: one step per enable, no drift between enables
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 64'd1));
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    generate
        if (DIV > 1) begin : g_space
            assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
        for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
            // R5: rise only after a fresh step that equals the compare value
            assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq[i]) |-> $past(fresh && (count[WORD_W-1:0] == cmp_val[i])));
            // R6: fall only after an acknowledge with this bit set
            assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(irq[i]) |-> $past(bus_sel && bus_wr && (bus_addr == 5'h00) && bus_wdata[i]));
        end
    endgenerate

    // R10: error pulses only follow an access
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));
endmodule

bind usec_sys_timer usec_sys_timer_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .fresh     (fresh),
    .count     (count),
    .cmp_val   (cmp_val),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .irq       (irq)
);

// File: tb/usec_sys_timer_test.sv
module usec_sys_timer_test;
    localparam int CLK_HZ = 4_000_000;   // DIV = 4

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usec_sys_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(1_000_000)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_data;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'h00, 32'h0,         32'h0,         1'b0, 4'd9},  // R9 status
        '{1'b0, 5'h0C, 32'h0,         32'h0,         1'b0, 4'd9},  // R9 cmp0
        '{1'b0, 5'h18, 32'h0,         32'h0,         1'b0, 4'd9},  // R9 cmp3
        '{1'b1, 5'h10, 32'hA5A50001,  32'h0,         1'b0, 4'd10}, // R10 write ok
        '{1'b0, 5'h10, 32'h0,         32'hA5A50001,  1'b0, 4'd4},  // R4
        '{1'b1, 5'h14, 32'h12345678,  32'h0,         1'b0, 4'd4},  // R4
        '{1'b0, 5'h14, 32'h0,         32'h12345678,  1'b0, 4'd4},  // R4
        '{1'b0, 5'h1C, 32'h0,         32'h0,         1'b1, 4'd8},  // R8
        '{1'b1, 5'h1C, 32'hFFFFFFFF,  32'h0,         1'b1, 4'd8},  // R8
        '{1'b0, 5'h12, 32'h0,         32'h0,         1'b1, 4'd8},  // R8 misaligned
        '{1'b1, 5'h0E, 32'hFFFFFFFF,  32'h0,         1'b1, 4'd8},  // R8 misaligned write
        '{1'b0, 5'h0C, 32'h0,         32'h0,         1'b0, 4'd8},  // R8 cmp0 untouched
        '{1'b1, 5'h08, 32'hFFFFFFFF,  32'h0,         1'b1, 4'd7},  // R7
        '{1'b0, 5'h08, 32'h0,         32'h0,         1'b0, 4'd3},  // R3 shadow still 0
        '{1'b0, 5'h00, 32'h0,         32'h0,         1'b0, 4'd6}   // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [4:0] addr, input logic [31:0] wdata,
                          output logic [31:0] rdata, output logic err);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wdata;
        @(negedge clk);
        rdata = bus_rdata; err = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a, b, l;
        logic        er;
        @(negedge clk);
        do_reset();
        check("R9 irq after reset", 32'(irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, er);
            check($sformatf("R%0d vec%0d data", VECS[i].req, i), rd, VECS[i].exp_data);
            check($sformatf("R%0d vec%0d err", VECS[i].req, i), 32'(er), 32'(VECS[i].exp_err));
        end

        // R1 R2: 80 clocks between samples -> 20 steps
        access(1'b0, 5'h04, 32'h0, a, er);
        repeat (79) @(negedge clk);
        access(1'b0, 5'h04, 32'h0, b, er);
        check("R1 step count over 80 clocks", b - a, 32'd20);
        access(1'b0, 5'h08, 32'h0, rd, er);
        check("R2 R3 high word", rd, 32'h0);

        // R7: write to low word ignored
        access(1'b0, 5'h04, 32'h0, a, er);
        access(1'b1, 5'h04, 32'hFFFF0000, rd, er);
        check("R7 write low err", 32'(er), 32'h1);
        repeat (38) @(negedge clk);
        access(1'b0, 5'h04, 32'h0, b, er);
        check("R7 counter unaffected", b - a, 32'd10);

        // R5: channel 0 matches
        access(1'b0, 5'h04, 32'h0, l, er);
        access(1'b1, 5'h0C, l + 32'd30, rd, er);
        repeat (200) @(negedge clk);
        check("R5 irq after match", 32'(irq), 32'h1);
        access(1'b0, 5'h00, 32'h0, rd, er);
        check("R5 status after match", rd, 32'h1);
        repeat (100) @(negedge clk);
        check("R5 flag held", 32'(irq), 32'h1);

        // R6: acknowledge
        access(1'b1, 5'h00, 32'h1, rd, er);
        check("R6 irq cleared", 32'(irq), 32'h0);
        access(1'b0, 5'h00, 32'h0, rd, er);
        check("R6 status cleared", rd, 32'h0);

        // R6: zero bits keep their value
        access(1'b0, 5'h04, 32'h0, l, er);
        access(1'b1, 5'h10, l + 32'd30, rd, er);
        access(1'b1, 5'h14, l + 32'd32, rd, er);
        repeat (200) @(negedge clk);
        check("R5 two channels", 32'(irq), 32'h6);
        access(1'b1, 5'h00, 32'h2, rd, er);
        check("R6 partial ack irq", 32'(irq), 32'h4);
        access(1'b0, 5'h00, 32'h0, rd, er);
        check("R6 partial ack status", rd, 32'h4);
        access(1'b0, 5'h10, 32'h0, rd, er);
        check("R4 cmp1 readback", rd, l + 32'd30);

        // R9: reset mid-run
        do_reset();
        check("R9 irq cleared", 32'(irq), 32'h0);
        access(1'b0, 5'h00, 32'h0, rd, er);
        check("R9 status cleared", rd, 32'h0);
        access(1'b0, 5'h14, 32'h0, rd, er);
        check("R9 cmp2 cleared", rd, 32'h0);
        access(1'b0, 5'h04, 32'h0, rd, er);
        check("R9 counter restarted", 32'(rd < 32'd4), 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule